// File: doc/BRIEF.md
# 8-bit Timer with Dual Compare

This block is an 8-bit counter with two compare channels, meant to sit beside a host that sets it up through simple write strobes. A clock-select field picks how often the counter advances. The choices are stopped, every system clock, or one of six prescaled rates taken from a free-running divider. A mode field picks the counting sequence and the waveform rule. The four sequences are a plain wrapping count, a count that restarts when it equals compare A, a fast single-slope PWM, and a dual-slope (phase-correct) PWM.

Each channel compares the count with its own compare register at all times. When a timer tick is taken while the two are equal, that channel's flag is set and its waveform output is updated as the mode requires. An overflow flag marks the end of each period. The host clears a flag by pulsing the matching clear strobe. Outputs that show when the count is at its top or bottom value let the surrounding logic see the extreme points.

Top module: `tmr8_dual_cmp`

## Requirements
- R1: `clkSel` encodes the tick source. 0 means no tick. 1 means every clock. Codes 2 to 7 divide by 8, 32, 64, 128, 256 and 1024. A 10-bit divider counts from 0 after reset, and a tick for divide-by-2^k occurs on every clock whose divider value has its low k bits all ones.
- R2: While `clkSel` is 0 the count holds its value, but a host write still loads it.
- R3: When `wrCount` is high, the count takes `wrData` at the next edge. This overrides any increment, decrement or clear from a tick in the same cycle.
- R4: `modeSel` encodes the counting sequence. 0 is normal: count up and wrap from 255 to 0. 1 is clear-on-compare: the count goes to 0 on a tick taken while it equals compare A, and otherwise counts up. 2 is fast PWM: count up and wrap. 3 is phase-correct: count up to 255, then down to 0, then up again.
- R5: Compare flag A (or B) is set at a tick taken while the count equals compare register A (or B). Compare registers load from `wrData` on `wrCmpA`/`wrCmpB` at the next edge.
- R6: A clear strobe (`clrCmpA`, `clrCmpB`, `clrOvf`) clears its flag at the next edge. If the flag's set condition occurs in the same cycle, the set wins.
- R7: The overflow flag is set at a tick taken while the count is 255 in modes 0, 1 and 2. In mode 3 it is set at a tick taken while the count is 0.
- R8: In modes 0 and 1, each waveform output toggles on a tick taken while its channel matches.
- R9: In fast PWM, a waveform output is set on a tick taken at count 255. Otherwise it is cleared on a tick taken at a match. With a compare value of 255 the output stays high from the first wrap onward.
- R10: In phase-correct mode, a tick taken at a match clears the output if that tick steps the count up, and sets it if that tick steps the count down. A compare value of 255 gives a constant high; a compare value of 0 gives a constant low.
- R11: `atMax` is high exactly when the count is 255. `atBottom` is high exactly when the count is 0.
- R12: After reset the count, compare registers, divider, direction, all flags and both waveform outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clkSel | input | 3 | Tick source select |
| modeSel | input | 2 | Counting and waveform mode |
| wrCount | input | 1 | Load count from wrData |
| wrCmpA | input | 1 | Load compare A from wrData |
| wrCmpB | input | 1 | Load compare B from wrData |
| wrData | input | 8 | Host write data |
| clrOvf | input | 1 | Clear overflow flag |
| clrCmpA | input | 1 | Clear compare flag A |
| clrCmpB | input | 1 | Clear compare flag B |
| count | output | 8 | Current count |
| ovfFlag | output | 1 | Overflow flag |
| cmpFlagA | output | 1 | Compare flag A |
| cmpFlagB | output | 1 | Compare flag B |
| waveA | output | 1 | Waveform output A |
| waveB | output | 1 | Waveform output B |
| atMax | output | 1 | Count equals 255 |
| atBottom | output | 1 | Count equals 0 |

## Verification
Two pairs of events can land in the same cycle. A host write to the count can coincide with a tick that would increment, decrement or clear it. A flag clear strobe can coincide with that flag's own set condition. Both collisions are provoked by a pseudo-random phase at divide-by-1 and divide-by-8, which fires writes and clear strobes at random while ticks arrive on every clock or every eighth clock. The result is judged every cycle against a requirement-level model in the bench, where the write beats the tick and the set beats the clear.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_CTC    = 2'd1,
    MODE_FAST   = 2'd2,
    MODE_PHASE  = 2'd3
  } tmrMode_e;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic load;
    logic clear;
    logic inc;
    logic dec;
  } cntCmd_t;
endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale #(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] clkSel,
  output logic       tick
);
  localparam int N_SEL = 8;

  function automatic int tapShift(input int sel);
    case (sel)
      2:       return 3;
      3:       return 5;
      4:       return 6;
      5:       return 7;
      6:       return 8;
      default: return 10;
    endcase
  endfunction

  logic [PRE_W-1:0] preCnt;
  logic [N_SEL-1:0] tapHit;

  always_ff @(posedge clk) begin
    if (!rst_n) preCnt <= '0;
    else        preCnt <= preCnt + 1'b1;
  end

  for (genvar i = 0; i < N_SEL; i++) begin : g_tap
    if (i == 0) begin : g_stop
      assign tapHit[i] = 1'b0;
    end else if (i == 1) begin : g_full
      assign tapHit[i] = 1'b1;
    end else begin : g_div
      localparam int SH = tapShift(i);
      assign tapHit[i] = &preCnt[SH-1:0];
    end
  end

  assign tick = tapHit[clkSel];
endmodule

// File: rtl/tmr8_dp.sv
module tmr8_dp
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cntCmd_t          cmd,
  input  logic             wrCmpA,
  input  logic             wrCmpB,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cmpA,
  output logic [CNT_W-1:0] cmpB,
  output logic             matchA,
  output logic             matchB,
  output logic             atMax,
  output logic             atBottom
);
  always_ff @(posedge clk) begin
    if (!rst_n)         count <= '0;
    else if (cmd.load)  count <= wrData;
    else if (cmd.clear) count <= '0;
    else if (cmd.inc)   count <= count + 1'b1;
    else if (cmd.dec)   count <= count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmpA <= '0;
      cmpB <= '0;
    end else begin
      if (wrCmpA) cmpA <= wrData;
      if (wrCmpB) cmpB <= wrData;
    end
  end

  assign matchA   = (count == cmpA);
  assign matchB   = (count == cmpB);
  assign atMax    = (count == {CNT_W{1'b1}});
  assign atBottom = (count == '0);
endmodule

// File: rtl/tmr8_ctrl.sv
module tmr8_ctrl
  import tmr8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] modeSel,
  input  logic       wrCount,
  input  logic       clrOvf,
  input  logic       clrCmpA,
  input  logic       clrCmpB,
  input  logic       matchA,
  input  logic       matchB,
  input  logic       atMax,
  input  logic       atBottom,
  output cntCmd_t    cmd,
  output logic       ovfFlag,
  output logic       cmpFlagA,
  output logic       cmpFlagB,
  output logic       waveA,
  output logic       waveB
);
  localparam int N_CH = 2;

  tmrMode_e        mode;
  logic            dirDown;
  logic            stepDown;
  logic            ovfSet;
  logic [N_CH-1:0] match, clrCh, flag, wave;

  assign mode     = tmrMode_e'(modeSel);
  assign match    = {matchB, matchA};
  assign clrCh    = {clrCmpB, clrCmpA};
  assign stepDown = (mode == MODE_PHASE) && (dirDown ? !atBottom : atMax);
  assign ovfSet   = tick && ((mode == MODE_PHASE) ? atBottom : atMax);

  always_comb begin
    cmd       = '0;
    cmd.load  = wrCount;
    cmd.clear = tick && (mode == MODE_CTC) && matchA;
    cmd.dec   = tick && stepDown;
    cmd.inc   = tick && !stepDown && !cmd.clear;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   dirDown <= 1'b0;
    else if (mode != MODE_PHASE)  dirDown <= 1'b0;
    else if (tick)                dirDown <= stepDown;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ovfFlag <= 1'b0;
    else if (ovfSet) ovfFlag <= 1'b1;
    else if (clrOvf) ovfFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= '0;
      wave <= '0;
    end else begin
      for (int i = 0; i < N_CH; i++) begin
        if (tick && match[i]) flag[i] <= 1'b1;
        else if (clrCh[i])    flag[i] <= 1'b0;

        if (tick) begin
          case (mode)
            MODE_FAST: begin
              if (atMax)         wave[i] <= 1'b1;
              else if (match[i]) wave[i] <= 1'b0;
            end
            MODE_PHASE: begin
              if (match[i]) wave[i] <= stepDown;
            end
            default: begin
              if (match[i]) wave[i] <= ~wave[i];
            end
          endcase
        end
      end
    end
  end

  assign cmpFlagA = flag[0];
  assign cmpFlagB = flag[1];
  assign waveA    = wave[0];
  assign waveB    = wave[1];
endmodule

// File: rtl/tmr8_dual_cmp.sv
module tmr8_dual_cmp
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       clkSel,
  input  logic [1:0]       modeSel,
  input  logic             wrCount,
  input  logic             wrCmpA,
  input  logic             wrCmpB,
  input  logic [CNT_W-1:0] wrData,
  input  logic             clrOvf,
  input  logic             clrCmpA,
  input  logic             clrCmpB,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag,
  output logic             cmpFlagA,
  output logic             cmpFlagB,
  output logic             waveA,
  output logic             waveB,
  output logic             atMax,
  output logic             atBottom
);
  logic             tick;
  logic             matchA, matchB;
  logic [CNT_W-1:0] cmpARef, cmpBRef;
  cntCmd_t          cmd;

  tmr8_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clkSel(clkSel), .tick(tick)
  );

  tmr8_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .modeSel(modeSel),
    .wrCount(wrCount), .clrOvf(clrOvf), .clrCmpA(clrCmpA), .clrCmpB(clrCmpB),
    .matchA(matchA), .matchB(matchB), .atMax(atMax), .atBottom(atBottom),
    .cmd(cmd), .ovfFlag(ovfFlag), .cmpFlagA(cmpFlagA), .cmpFlagB(cmpFlagB),
    .waveA(waveA), .waveB(waveB)
  );

  tmr8_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .wrCmpA(wrCmpA), .wrCmpB(wrCmpB),
    .wrData(wrData), .count(count), .cmpA(cmpARef), .cmpB(cmpBRef),
    .matchA(matchA), .matchB(matchB), .atMax(atMax), .atBottom(atBottom)
  );
endmodule

// File: rtl/tmr8_dual_cmp_chk.sv
module tmr8_dual_cmp_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       clkSel,
  input logic [1:0]       modeSel,
  input logic             wrCount,
  input logic [CNT_W-1:0] wrData,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cmpARef,
  input logic             tick,
  input logic             ovfFlag,
  input logic             cmpFlagA,
  input logic             waveA
);
  a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (clkSel == 3'd0 && !wrCount) |=> $stable(count));

  a_r3_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wrCount |=> (count == $past(wrData)));

  a_r4_ctc_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (modeSel == 2'd1 && tick && !wrCount && count == cmpARef) |=> (count == '0));

  a_r5_flag_a_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == cmpARef) |=> cmpFlagA);

  a_r7_phase_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (modeSel == 2'd3 && tick && count == '0) |=> ovfFlag);

  a_r9_fast_top_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (modeSel == 2'd2 && tick && count == {CNT_W{1'b1}}) |=> waveA);
endmodule

bind tmr8_dual_cmp tmr8_dual_cmp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clkSel(clkSel), .modeSel(modeSel),
  .wrCount(wrCount), .wrData(wrData), .count(count), .cmpARef(cmpARef),
  .tick(tick), .ovfFlag(ovfFlag), .cmpFlagA(cmpFlagA), .waveA(waveA)
);

// File: tb/tmr8_dual_cmp_tb.sv
module tmr8_dual_cmp_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] clkSel = '0;
  logic [1:0] modeSel = '0;
  logic       wrCount = 0, wrCmpA = 0, wrCmpB = 0;
  logic [7:0] wrData = '0;
  logic       clrOvf = 0, clrCmpA = 0, clrCmpB = 0;
  logic [7:0] count;
  logic       ovfFlag, cmpFlagA, cmpFlagB, waveA, waveB, atMax, atBottom;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // reference state
  logic [9:0] mPre;
  logic [7:0] mCnt, mA, mB;
  logic       mDir, mOvf, mFa, mFb, mWa, mWb;

  always #2 clk = ~clk;

  tmr8_dual_cmp u_dut (
    .clk(clk), .rst_n(rst_n), .clkSel(clkSel), .modeSel(modeSel),
    .wrCount(wrCount), .wrCmpA(wrCmpA), .wrCmpB(wrCmpB), .wrData(wrData),
    .clrOvf(clrOvf), .clrCmpA(clrCmpA), .clrCmpB(clrCmpB),
    .count(count), .ovfFlag(ovfFlag), .cmpFlagA(cmpFlagA), .cmpFlagB(cmpFlagB),
    .waveA(waveA), .waveB(waveB), .atMax(atMax), .atBottom(atBottom)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mPre = '0; mCnt = '0; mA = '0; mB = '0;
    mDir = 0; mOvf = 0; mFa = 0; mFb = 0; mWa = 0; mWb = 0;
  endtask

  function automatic logic nextWave(input logic [1:0] md, input logic cur,
                                    input logic hit, input logic top, input logic down);
    case (md)
      2'd2:    return top ? 1'b1 : (hit ? 1'b0 : cur);
      2'd3:    return hit ? down : cur;
      default: return hit ? ~cur : cur;
    endcase
  endfunction

  // R1 tick rule, R4 sequences, R5-R10 flag and wave rules
  task automatic modelStep();
    int  sh;
    logic tk, down, ha, hb, top, bot;
    case (clkSel)
      3'd2: sh = 3;  3'd3: sh = 5;  3'd4: sh = 6;
      3'd5: sh = 7;  3'd6: sh = 8;  default: sh = 10;
    endcase
    if (clkSel == 0)      tk = 0;
    else if (clkSel == 1) tk = 1;
    else                  tk = ((mPre & ((10'd1 << sh) - 1)) == ((10'd1 << sh) - 1));
    top  = (mCnt == 8'hFF);
    bot  = (mCnt == 8'h00);
    down = (modeSel == 3) && (mDir ? !bot : top);
    ha   = (mCnt == mA);
    hb   = (mCnt == mB);
    mPre = mPre + 1;
    if (tk && ((modeSel == 3) ? bot : top)) mOvf = 1; else if (clrOvf) mOvf = 0;
    if (tk && ha) mFa = 1; else if (clrCmpA) mFa = 0;
    if (tk && hb) mFb = 1; else if (clrCmpB) mFb = 0;
    if (tk) begin
      mWa = nextWave(modeSel, mWa, ha, top, down);
      mWb = nextWave(modeSel, mWb, hb, top, down);
    end
    if (wrCount)     mCnt = wrData;
    else if (tk) begin
      if (modeSel == 1 && ha) mCnt = 0;
      else if (down)          mCnt = mCnt - 1;
      else                    mCnt = mCnt + 1;
    end
    if (modeSel != 3) mDir = 0; else if (tk) mDir = down;
    if (wrCmpA) mA = wrData;
    if (wrCmpB) mB = wrData;
  endtask

  task automatic compareAll();
    chk("R1 R2 R3 R4 count", count, mCnt);
    chk("R6 R7 ovfFlag", ovfFlag, mOvf);
    chk("R5 R6 cmpFlagA", cmpFlagA, mFa);
    chk("R5 R6 cmpFlagB", cmpFlagB, mFb);
    chk("R8 R9 R10 waveA", waveA, mWa);
    chk("R8 R9 R10 waveB", waveB, mWb);
    chk("R11 atMax", atMax, (mCnt == 8'hFF));
    chk("R11 atBottom", atBottom, (mCnt == 8'h00));
  endtask

  task automatic stepClk();
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic doReset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    modelReset();
  endtask

  task automatic setCmp(input logic [7:0] a, input logic [7:0] b);
    wrCmpA = 1; wrData = a; stepClk(); wrCmpA = 0;
    wrCmpB = 1; wrData = b; stepClk(); wrCmpB = 0;
  endtask

  task automatic runFor(input int n);
    for (int i = 0; i < n; i++) stepClk();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [7:0] cmpSet [5];
    cmpSet = '{8'd0, 8'd255, 8'd128, 8'd5, 8'd200};
    clkSel = 3'd0;
    doReset();
    // R12 reset state
    chk("R12 count", count, 0);
    chk("R12 ovfFlag", ovfFlag, 0);
    chk("R12 cmpFlagA", cmpFlagA, 0);
    chk("R12 waveB", waveB, 0);
    chk("R12 atBottom", atBottom, 1);

    // R2: stopped counter holds, host writes still land
    runFor(20);
    wrCount = 1; wrData = 8'd77; stepClk(); wrCount = 0;
    runFor(20);
    chk("R2 stopped after write", count, 77);

    // mode x compare sweep at divide-by-1 (R4 R5 R7 R8 R9 R10)
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 5; c++) begin
        doReset();
        modeSel = m[1:0];
        clkSel  = 3'd0;
        setCmp(cmpSet[c], cmpSet[(c + 2) % 5]);
        clkSel = 3'd1;
        runFor(1100);
        clrOvf = 1; clrCmpA = 1; clrCmpB = 1; stepClk();
        clrOvf = 0; clrCmpA = 0; clrCmpB = 0;
        runFor(300);
      end
    end

    // R1 prescaler taps
    for (int s = 2; s < 8; s++) begin
      doReset();
      modeSel = 2'd0;
      clkSel  = s[2:0];
      setCmp(8'd3, 8'd1);
      runFor(4200);
    end

    // R3 R6 collisions: random writes and clear strobes against ticks
    lfsr = 16'hACE1;
    for (int m = 0; m < 4; m++) begin
      for (int s = 1; s < 3; s++) begin
        doReset();
        modeSel = m[1:0];
        clkSel  = s[2:0];
        for (int i = 0; i < 3000; i++) begin
          lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          wrData  = lfsr[15:8];
          wrCount = (lfsr[3:0] == 4'd0);
          wrCmpA  = (lfsr[6:4] == 3'd1) && !wrCount;
          wrCmpB  = (lfsr[6:4] == 3'd2) && !wrCount;
          clrOvf  = lfsr[7] & lfsr[2];
          clrCmpA = lfsr[8] & lfsr[1];
          clrCmpB = lfsr[9] & lfsr[0];
          stepClk();
        end
        wrCount = 0; wrCmpA = 0; wrCmpB = 0;
        clrOvf = 0; clrCmpA = 0; clrCmpB = 0;
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule